// File: doc/BRIEF.md
# Start-up Delay Sequencer

This block keeps the core clock-enable low after a reset event or a wake-up from power-down, and raises `ready` only when the selected clock source has had time to settle. The delay is counted in up to three phases. A stabilisation phase counts ticks of the system clock. After a reset event, and only then, two more phases follow: a fixed run of system-clock ticks, then an optional run of watchdog-oscillator ticks, about 4 ms or about 64 ms long.

The source select, start-up select and crystal range bit are sampled when the event arrives, and they are decoded into per-phase tick counts. A code with no defined meaning selects the longest delay the block can produce and raises `config_error`. All tick counts are parameters, so a short configuration can be used for testing. A new event that arrives during a count starts the sequence again.

FSM states: `ST_HALT` (after `rst_n`, waiting for the first event), `ST_STAB` (stabilisation), `ST_RST_CK` (fixed extra clock ticks after reset), `ST_RST_WDT` (watchdog ticks after reset), and `ST_RUN` (ready). Transitions:
- any state → `ST_STAB` on an event;
- `ST_STAB` → `ST_RST_CK` when its count completes after a reset or reserved code, otherwise → `ST_RUN`;
- `ST_RST_CK` → `ST_RST_WDT` when a watchdog count is selected, otherwise → `ST_RUN`;
- `ST_RST_WDT` → `ST_RUN` when its count completes.

Top module: `startup_seq`

## Requirements
- R1: After `rst_n` is released, `ready` and `config_error` are both low, and `ready` stays low until the first event.
- R2: Source code 00 (external clock, RC or 128 kHz) gives a stabilisation count of GEN_CK system ticks for every start-up code. After a reset, EXTRA_CK system ticks follow, then no watchdog ticks for start-up code 00, WDT_SHORT for 01 and WDT_LONG for 10.
- R3: Source code 01 (low-frequency crystal) stabilises for K1_CK ticks with start-up codes 00 and 01, and for LF_SLOW_CK ticks with code 10. After a reset, EXTRA_CK ticks follow, then WDT_SHORT for code 00 and WDT_LONG for codes 01 and 10.
- R4: Source code 10 (crystal) uses the index {xtal_sel, sut_sel}. Its stabilisation count is XF_CK for indices 0–1, K1_CK for 2–4 and XS_CK for 5–7. Its watchdog count after a reset is WDT_SHORT for indices 0, 3 and 6, WDT_LONG for 1, 4 and 7, and none for 2 and 5. EXTRA_CK always precedes the watchdog count.
- R5: After a wake event, only the stabilisation count is applied. No EXTRA_CK ticks are counted and no watchdog ticks are needed.
- R6: The stabilisation and EXTRA_CK phases advance only on `sys_tick`, and the watchdog phase advances only on `wdt_tick`.
- R7: Source code 11, and start-up code 11 with source 00 or 01, are reserved. For either event kind they give the largest stabilisation count, then EXTRA_CK, then WDT_LONG. `config_error` is high from the cycle after such an event until the cycle after the next event with a valid code.
- R8: An event that arrives during a count restarts the sequence from that event. When both events arrive in the same cycle, the reset event takes precedence.
- R9: The configuration is sampled on the event cycle. Later changes have no effect on the running count or on `config_error`.
- R10: `ready` is low in the cycle after any event. Once high, it stays high until the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_src | input | 2 | Clock source code (00 generic, 01 low-frequency crystal, 10 crystal, 11 reserved) |
| sut_sel | input | 2 | Start-up time select |
| xtal_sel | input | 1 | Crystal range bit, upper bit of the crystal index |
| start_reset | input | 1 | Reset event, one cycle |
| start_wake | input | 1 | Wake-from-power-down event, one cycle |
| sys_tick | input | 1 | One tick of the selected system clock |
| wdt_tick | input | 1 | One tick of the watchdog oscillator |
| ready | output | 1 | Releases the CPU clock |
| config_error | output | 1 | Latched reserved-code flag |

## Verification
The hardest situations to reach are those where the two tick streams must be told apart. Examples are a reset sequence stalled in its watchdog phase while system ticks continue, and a stabilisation phase stalled with no system ticks at all. The bench gets there by holding one tick input low for tens of cycles and checking that `ready` stays low, then re-enabling that input and counting the remaining cycles exactly. Restarts during a count and a configuration change after the event are produced the same way, with events placed at known cycle offsets.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_STAB,
        ST_RST_CK,
        ST_RST_WDT,
        ST_RUN
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_GENERIC = 2'b00,
        SRC_LFXTAL  = 2'b01,
        SRC_XTAL    = 2'b10,
        SRC_RSVD    = 2'b11
    } clk_src_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/startup_delay_decode.sv
module startup_delay_decode
    import startup_seq_pkg::*;
#(
    parameter int unsigned CW         = 16,
    parameter int unsigned GEN_CK     = 6,
    parameter int unsigned XF_CK      = 258,
    parameter int unsigned K1_CK      = 1024,
    parameter int unsigned XS_CK      = 16384,
    parameter int unsigned LF_SLOW_CK = 32768,
    parameter int unsigned LONG_STAB  = 32768,
    parameter int unsigned WDT_SHORT  = 512,
    parameter int unsigned WDT_LONG   = 8192
) (
    input  logic [1:0]    src,
    input  logic [1:0]    sut,
    input  logic          xsel,
    output logic [CW-1:0] stab_len,
    output logic [CW-1:0] wdt_len,
    output logic          reserved
);
    localparam logic [CW-1:0] L_GEN  = CW'(GEN_CK);
    localparam logic [CW-1:0] L_XF   = CW'(XF_CK);
    localparam logic [CW-1:0] L_K1   = CW'(K1_CK);
    localparam logic [CW-1:0] L_XS   = CW'(XS_CK);
    localparam logic [CW-1:0] L_LF   = CW'(LF_SLOW_CK);
    localparam logic [CW-1:0] L_MAX  = CW'(LONG_STAB);
    localparam logic [CW-1:0] L_WS   = CW'(WDT_SHORT);
    localparam logic [CW-1:0] L_WL   = CW'(WDT_LONG);
    localparam logic [CW-1:0] L_NONE = '0;

    logic [2:0] xidx;
    assign xidx = {xsel, sut};

    always_comb begin
        stab_len = L_MAX;
        wdt_len  = L_WL;
        reserved = 1'b0;
        unique case (clk_src_e'(src))
            SRC_GENERIC: begin
                stab_len = L_GEN;
                unique case (sut)
                    2'b00:   wdt_len = L_NONE;
                    2'b01:   wdt_len = L_WS;
                    2'b10:   wdt_len = L_WL;
                    default: begin stab_len = L_MAX; reserved = 1'b1; end
                endcase
            end
            SRC_LFXTAL: begin
                unique case (sut)
                    2'b00:   begin stab_len = L_K1; wdt_len = L_WS; end
                    2'b01:   begin stab_len = L_K1; wdt_len = L_WL; end
                    2'b10:   begin stab_len = L_LF; wdt_len = L_WL; end
                    default: reserved = 1'b1;
                endcase
            end
            SRC_XTAL: begin
                unique case (xidx)
                    3'd0:    begin stab_len = L_XF; wdt_len = L_WS;   end
                    3'd1:    begin stab_len = L_XF; wdt_len = L_WL;   end
                    3'd2:    begin stab_len = L_K1; wdt_len = L_NONE; end
                    3'd3:    begin stab_len = L_K1; wdt_len = L_WS;   end
                    3'd4:    begin stab_len = L_K1; wdt_len = L_WL;   end
                    3'd5:    begin stab_len = L_XS; wdt_len = L_NONE; end
                    3'd6:    begin stab_len = L_XS; wdt_len = L_WS;   end
                    default: begin stab_len = L_XS; wdt_len = L_WL;   end
                endcase
            end
            default: reserved = 1'b1;
        endcase
    end

endmodule

// File: rtl/startup_tick_counter.sv
module startup_tick_counter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;

    assign hit = tick && (cnt == (limit - CW'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_seq_pkg::*;
#(
    parameter int unsigned GEN_CK     = 6,
    parameter int unsigned EXTRA_CK   = 14,
    parameter int unsigned XF_CK      = 258,
    parameter int unsigned K1_CK      = 1024,
    parameter int unsigned XS_CK      = 16384,
    parameter int unsigned LF_SLOW_CK = 32768,
    parameter int unsigned WDT_SHORT  = 512,
    parameter int unsigned WDT_LONG   = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_src,
    input  logic [1:0] sut_sel,
    input  logic       xtal_sel,
    input  logic       start_reset,
    input  logic       start_wake,
    input  logic       sys_tick,
    input  logic       wdt_tick,
    output logic       ready,
    output logic       config_error
);
    localparam int unsigned LONG_STAB =
        umax(umax(umax(GEN_CK, XF_CK), umax(K1_CK, XS_CK)), LF_SLOW_CK);
    localparam int unsigned MAX_ALL =
        umax(LONG_STAB, umax(EXTRA_CK, umax(WDT_SHORT, WDT_LONG)));
    localparam int unsigned CW = $clog2(MAX_ALL + 1);
    localparam logic [CW-1:0] L_EXTRA = CW'(EXTRA_CK);

    seq_state_e    state, state_nx;
    logic          ev;
    logic [CW-1:0] dec_stab, dec_wdt;
    logic          dec_rsvd;
    logic [CW-1:0] stab_q, wdt_q;
    logic          ext_q, err_q;
    logic          cnt_tick, cnt_hit;
    logic [CW-1:0] cnt_limit;

    assign ev = start_reset | start_wake;

    startup_delay_decode #(
        .CW(CW), .GEN_CK(GEN_CK), .XF_CK(XF_CK), .K1_CK(K1_CK), .XS_CK(XS_CK),
        .LF_SLOW_CK(LF_SLOW_CK), .LONG_STAB(LONG_STAB),
        .WDT_SHORT(WDT_SHORT), .WDT_LONG(WDT_LONG)
    ) u_decode (
        .src(clk_src), .sut(sut_sel), .xsel(xtal_sel),
        .stab_len(dec_stab), .wdt_len(dec_wdt), .reserved(dec_rsvd)
    );

    startup_tick_counter #(.CW(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .clear(ev | cnt_hit),
        .tick(cnt_tick), .limit(cnt_limit), .hit(cnt_hit)
    );

    // configuration captured on the event cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stab_q <= '0;
            wdt_q  <= '0;
            ext_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (ev) begin
            stab_q <= dec_stab;
            wdt_q  <= dec_wdt;
            ext_q  <= start_reset | dec_rsvd;
            err_q  <= dec_rsvd;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (ev) begin
            state_nx = ST_STAB;
        end else begin
            unique case (state)
                ST_HALT:    state_nx = ST_HALT;
                ST_STAB:    if (cnt_hit) state_nx = ext_q ? ST_RST_CK : ST_RUN;
                ST_RST_CK:  if (cnt_hit) state_nx = (wdt_q == '0) ? ST_RUN : ST_RST_WDT;
                ST_RST_WDT: if (cnt_hit) state_nx = ST_RUN;
                ST_RUN:     state_nx = ST_RUN;
                default:    state_nx = ST_HALT;
            endcase
        end
    end

    // outputs and per-phase counter selection
    always_comb begin
        cnt_tick  = 1'b0;
        cnt_limit = stab_q;
        unique case (state)
            ST_STAB:    begin cnt_tick = sys_tick; cnt_limit = stab_q;  end
            ST_RST_CK:  begin cnt_tick = sys_tick; cnt_limit = L_EXTRA; end
            ST_RST_WDT: begin cnt_tick = wdt_tick; cnt_limit = wdt_q;   end
            default:    begin cnt_tick = 1'b0;     cnt_limit = stab_q;  end
        endcase
        ready        = (state == ST_RUN);
        config_error = err_q;
    end

endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] clk_src,
    input logic [1:0] sut_sel,
    input logic       start_reset,
    input logic       start_wake,
    input logic       sys_tick,
    input logic       wdt_tick,
    input logic       ready,
    input logic       config_error
);
    logic ev, rsvd;
    assign ev   = start_reset | start_wake;
    assign rsvd = (clk_src == 2'b11) || ((clk_src != 2'b10) && (sut_sel == 2'b11));

    assert_low_after_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> !ready);

    assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !ev) |=> ready);

    assert_rise_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(sys_tick || wdt_tick));

    assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && rsvd) |=> config_error);

    assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !rsvd) |=> !config_error);

    assert_err_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ev |=> $stable(config_error));

endmodule

bind startup_seq startup_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clk_src(clk_src), .sut_sel(sut_sel),
    .start_reset(start_reset), .start_wake(start_wake),
    .sys_tick(sys_tick), .wdt_tick(wdt_tick),
    .ready(ready), .config_error(config_error)
);

// File: tb/startup_seq_tb.sv
`timescale 1ns/1ps
module startup_seq_tb;
    localparam int GEN = 2, EXT = 3, XF = 4, K1 = 5, XS = 7, LF = 9, WS = 11, WL = 17;
    localparam int LONGEST = LF + EXT + WL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] clk_src = 2'b00, sut_sel = 2'b00;
    logic xtal_sel = 1'b0, start_reset = 1'b0, start_wake = 1'b0;
    logic sys_tick = 1'b1, wdt_tick = 1'b1;
    logic ready, config_error;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #2 clk = ~clk;

    startup_seq #(.GEN_CK(GEN), .EXTRA_CK(EXT), .XF_CK(XF), .K1_CK(K1), .XS_CK(XS),
                  .LF_SLOW_CK(LF), .WDT_SHORT(WS), .WDT_LONG(WL)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_src(clk_src), .sut_sel(sut_sel),
        .xtal_sel(xtal_sel), .start_reset(start_reset), .start_wake(start_wake),
        .sys_tick(sys_tick), .wdt_tick(wdt_tick), .ready(ready), .config_error(config_error));

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            finish_run();
        end
    end

    function automatic bit is_rsvd(input int s, input int u);
        return (s == 3) || (s != 2 && u == 3);
    endfunction

    function automatic int exp_delay(input int s, input int x, input int u, input bit rst);
        int st, wd, idx;
        if (is_rsvd(s, u)) return LONGEST;
        idx = x * 4 + u;
        if (s == 0) begin
            st = GEN; wd = (u == 0) ? 0 : (u == 1) ? WS : WL;
        end else if (s == 1) begin
            st = (u == 2) ? LF : K1; wd = (u == 0) ? WS : WL;
        end else begin
            st = (idx < 2) ? XF : (idx < 5) ? K1 : XS;
            wd = (idx % 3 == 0) ? WS : (idx % 3 == 1) ? WL : 0;
        end
        return rst ? st + EXT + wd : st;
    endfunction

    task automatic setcfg(input int s, input int x, input int u);
        clk_src = 2'(s); xtal_sel = 1'(x); sut_sel = 2'(u);
    endtask

    task automatic fire(input bit r, input bit w);
        @(negedge clk); start_reset = r; start_wake = w;
        @(negedge clk); start_reset = 1'b0; start_wake = 1'b0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!ready && n < 400) begin n++; @(negedge clk); end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 ready after reset", ready, 0);
        check("R1 error after reset", config_error, 0);

        // sweep of every configuration for both event kinds
        for (int k = 0; k < 2; k++)
            for (int s = 0; s < 4; s++)
                for (int x = 0; x < 2; x++)
                    for (int u = 0; u < 4; u++) begin
                        string tag;
                        tag = is_rsvd(s, u) ? "R7" : (s == 0) ? "R2" : (s == 1) ? "R3" : "R4";
                        if (k == 0) tag = {tag, "/R5 wake"};
                        setcfg(s, x, u);
                        fire(k == 1, k == 0);
                        check({tag, " ready low after event R10"}, ready, 0);
                        count_low(n);
                        check({tag, " delay"}, n, exp_delay(s, x, u, k == 1));
                        check({tag, " config_error"}, config_error, is_rsvd(s, u));
                    end

        // R10: ready stays high without events
        repeat (20) @(negedge clk);
        check("R10 ready held", ready, 1);

        // R6: stabilisation waits for sys_tick
        setcfg(0, 0, 0); sys_tick = 1'b0;
        fire(0, 1);
        repeat (40) @(negedge clk);
        check("R6 no sys ticks", ready, 0);
        sys_tick = 1'b1; count_low(n);
        check("R6 resumed stab", n, GEN);

        // R6: watchdog phase waits for wdt_tick
        setcfg(0, 0, 1); wdt_tick = 1'b0;
        fire(1, 0);
        repeat (40) @(negedge clk);
        check("R6 no wdt ticks", ready, 0);
        wdt_tick = 1'b1; count_low(n);
        check("R6 resumed wdt", n, WS);

        // R5: wake needs no watchdog ticks
        wdt_tick = 1'b0;
        setcfg(0, 0, 2); fire(0, 1); count_low(n);
        check("R5 wake generic without wdt", n, GEN);
        setcfg(2, 0, 1); fire(0, 1); count_low(n);
        check("R5 wake crystal without wdt", n, XF);
        wdt_tick = 1'b1;

        // R8: restart mid-count
        setcfg(0, 0, 2); fire(1, 0);
        repeat (3) @(negedge clk);
        fire(0, 1); count_low(n);
        check("R8 wake restarts reset count", n, GEN);
        setcfg(1, 0, 2); fire(0, 1);
        repeat (3) @(negedge clk);
        fire(1, 0); count_low(n);
        check("R8 reset restarts wake count", n, LF + EXT + WL);
        setcfg(0, 0, 1); fire(1, 1); count_low(n);
        check("R8 reset wins over wake", n, GEN + EXT + WS);

        // R9: config change after event is ignored
        setcfg(2, 1, 1); fire(1, 0);
        setcfg(3, 0, 3); count_low(n);
        check("R9 count unaffected", n, XS + EXT);
        check("R9 error unaffected", config_error, 0);

        // R7: error set, then cleared by a valid event
        fire(0, 1); count_low(n);
        check("R7 reserved wake delay", n, LONGEST);
        check("R7 error set", config_error, 1);
        setcfg(1, 0, 0); fire(0, 1);
        check("R7 error cleared next cycle", config_error, 0);
        count_low(n);
        check("R3 lf crystal wake", n, K1);

        finish_run();
    end
endmodule